// File: doc/BRIEF.md
# Firmware Image Validator and Loader

The block takes a firmware image that already sits in a word-addressed image RAM, checks it word by word and then copies its code blocks into an engine's instruction or data memory. A pulse on `start` launches a run. The block reads the image through a synchronous read port with one cycle of latency. It first checks the three-word header: the magic value, the identity word and the payload length. It then looks for the end marker of the block table. Next it validates every table entry and the small header of every code block. Only when all of these checks pass does it make a second walk over the table. On that walk it sends one write command per data word to the memory write port.

An image may be stored in either byte order. If the first word holds the magic value with its bytes reversed, every later word is byte-reversed as it is read. Each failure kind stops the run at once and ends it with its own error code. Because all checks complete before the first write, a rejected image never leaves a partial load in the engine's memories. The block does not fetch the image from storage and does not start the engine.

Top module: `fw_image_loader`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_valid` are low and `err_code` is 0.
- R2: If `engine_busy` is high when `start` is taken, the run ends with error code 1 and issues no write command. `done` pulses in the next cycle and `busy` stays low.
- R3: Image word 0 must equal 0xFEEDF00D. If it equals 0x0DF0EDFE instead, every later word is byte-reversed before use. Any other value ends the run with error code 2.
- R4: Word 2 holds the payload size in words. `img_len` must equal that size plus 3, otherwise the run ends with error code 3.
- R5: Bits 27:24 of word 1 must equal `engine_id`, otherwise the run ends with error code 4.
- R6: When `legacy_mode` is high, a nonzero value in bits 31:28 of word 1 ends the run with error code 5. When `legacy_mode` is low, that field has no effect.
- R7: Table entry k has its type at image word 3+2k and its offset at word 4+2k. The first type equal to 0xF ends the table, and the number of entries before it is the block count. If no such type is found at a payload index 2k below the size (a size of 0 included), the run ends with error code 6.
- R8: A block offset is a payload index and must lie between 2*blocks+1 and size-2, both inclusive, otherwise the run ends with error code 7.
- R9: A table type other than 0 (instruction) or 1 (data) ends the run with error code 8. This check comes after the offset check of the same entry.
- R10: The code block at payload offset o holds its destination address at image word 3+o and its word count at 4+o. Destination plus count must not exceed `imem_limit` for type 0 or `dmem_limit` for type 1, otherwise the run ends with error code 9.
- R11: The offset plus 2 plus the count must not exceed the payload size, otherwise the run ends with error code 10. This check comes after the limit check.
- R12: Data word j of a block is read from image word 5+o+j. It is issued as one command with opcode 0x11 for instruction memory or 0x13 for data memory, with address destination+j. Blocks are issued in table order and words in ascending j.
- R13: No write command is issued in a run that ends with any error, even when the failing entry follows valid ones.
- R14: `busy` is high from the cycle after an accepted start until the run ends. `done` then pulses for one cycle with `busy` low, and `err_code` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| img_len | input | LEN_W | Image length in words |
| engine_id | input | 4 | Engine number the image must target |
| legacy_mode | input | 1 | Rejects images whose device field is nonzero |
| engine_busy | input | 1 | Engine is running; loading is refused |
| imem_limit | input | MAW+1 | Instruction memory size in words |
| dmem_limit | input | MAW+1 | Data memory size in words |
| img_rd_en | output | 1 | Image RAM read enable |
| img_addr | output | LEN_W | Image RAM word address |
| img_rdata | input | 32 | Image RAM read data, one cycle after the read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_code | output | 4 | Result of the last run, 0 when clean |
| cmd_valid | output | 1 | Write command valid |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | MAW | Destination word address |
| cmd_data | output | 32 | Word to write |

## Verification
The bench builds the block with an 8-bit image address and a 6-bit memory address, and sets the memory limits to 40 and 48 words. At these sizes every image fits a 256-word RAM model. The exact boundaries of the limit, offset and overrun checks can each be reached with only a few data words, so both sides of every boundary are tested. The bench then sweeps table sizes from zero to three blocks and word counts from zero to four, alternating the image byte order, and compares the full command stream against the layout the bench built itself.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

   typedef enum logic [3:0] {
      ERR_NONE    = 4'd0,
      ERR_BUSY    = 4'd1,
      ERR_MAGIC   = 4'd2,
      ERR_SIZE    = 4'd3,
      ERR_ENGINE  = 4'd4,
      ERR_DEVICE  = 4'd5,
      ERR_NO_EOF  = 4'd6,
      ERR_OFFSET  = 4'd7,
      ERR_TYPE    = 4'd8,
      ERR_LIMIT   = 4'd9,
      ERR_OVERRUN = 4'd10
   } fwl_err_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_MAGIC,
      ST_IDW,
      ST_SIZE,
      ST_SCAN,
      ST_BTYPE,
      ST_BOFF,
      ST_BDST,
      ST_BCNT,
      ST_BDATA,
      ST_FIN
   } fwl_state_e;

   localparam logic [31:0] TYPE_INSTR = 32'h0;
   localparam logic [31:0] TYPE_DATA  = 32'h1;
   localparam logic [31:0] TYPE_END   = 32'hF;

   function automatic logic [31:0] bswap32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

endpackage

// File: rtl/fwl_fetch.sv
// Read-data stage: marks the cycle the image RAM data is valid and
// reverses the byte order when the image was stored swapped.
module fwl_fetch
   import fwl_pkg::*;
#(
   parameter bit SWAP_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rd_req,
   input  logic        swap_i,
   input  logic [31:0] img_rdata,
   output logic        fvalid,
   output logic [31:0] fword
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fvalid <= 1'b0;
      else        fvalid <= rd_req;
   end

   generate
      if (SWAP_EN) begin : g_swap
         assign fword = swap_i ? bswap32(img_rdata) : img_rdata;
      end else begin : g_noswap
         logic unused_swap;
         assign unused_swap = swap_i;
         assign fword = img_rdata;
      end
   endgenerate

endmodule

// File: rtl/fwl_bounds.sv
// Range checks on raw 32-bit table and code-block fields, done in
// wide arithmetic so that no field wraps before it is compared.
module fwl_bounds #(
   parameter int LEN_W = 16,
   parameter int LIM_W = 14
) (
   input  logic [31:0]      off_i,
   input  logic [LEN_W-1:0] size_i,
   input  logic [LEN_W-1:0] nblk_i,
   input  logic [31:0]      dst_i,
   input  logic [31:0]      cnt_i,
   input  logic [LIM_W-1:0] lim_i,
   output logic             off_bad,
   output logic             limit_bad,
   output logic             overrun_bad
);

   localparam int XW = 34;

   logic [XW-1:0] off_x, size_x, tend_x, dst_x, cnt_x, lim_x;

   always_comb begin
      off_x  = XW'(off_i);
      size_x = XW'(size_i);
      tend_x = (XW'(nblk_i) << 1) + XW'(1);
      dst_x  = XW'(dst_i);
      cnt_x  = XW'(cnt_i);
      lim_x  = XW'(lim_i);
      off_bad     = ((off_x + XW'(2)) > size_x) || (off_x < tend_x);
      limit_bad   = (dst_x + cnt_x) > lim_x;
      overrun_bad = (off_x + XW'(2) + cnt_x) > size_x;
   end

endmodule

// File: rtl/fwl_cmd_out.sv
// Registered write-command port.
module fwl_cmd_out #(
   parameter int         MAW     = 13,
   parameter logic [7:0] OP_IMEM = 8'h11,
   parameter logic [7:0] OP_DMEM = 8'h13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           emit,
   input  logic           is_instr,
   input  logic [MAW-1:0] addr_i,
   input  logic [31:0]    data_i,
   output logic           cmd_valid,
   output logic [7:0]     cmd_op,
   output logic [MAW-1:0] cmd_addr,
   output logic [31:0]    cmd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_op    <= '0;
         cmd_addr  <= '0;
         cmd_data  <= '0;
      end else begin
         cmd_valid <= emit;
         if (emit) begin
            cmd_op   <= is_instr ? OP_IMEM : OP_DMEM;
            cmd_addr <= addr_i;
            cmd_data <= data_i;
         end
      end
   end

   AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_op == OP_IMEM || cmd_op == OP_DMEM)); // R12

endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader
   import fwl_pkg::*;
#(
   parameter int          LEN_W   = 16,
   parameter int          MAW     = 13,
   parameter logic [31:0] MAGIC   = 32'hFEEDF00D,
   parameter bit          SWAP_EN = 1'b1,
   parameter logic [7:0]  OP_IMEM = 8'h11,
   parameter logic [7:0]  OP_DMEM = 8'h13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] img_len,
   input  logic [3:0]       engine_id,
   input  logic             legacy_mode,
   input  logic             engine_busy,
   input  logic [MAW:0]     imem_limit,
   input  logic [MAW:0]     dmem_limit,
   output logic             img_rd_en,
   output logic [LEN_W-1:0] img_addr,
   input  logic [31:0]      img_rdata,
   output logic             busy,
   output logic             done,
   output logic [3:0]       err_code,
   output logic             cmd_valid,
   output logic [7:0]       cmd_op,
   output logic [MAW-1:0]   cmd_addr,
   output logic [31:0]      cmd_data
);

   localparam int LIM_W = MAW + 1;

   initial begin : g_param_chk
      assert (LEN_W >= 4 && LEN_W <= 30) else $fatal(1, "LEN_W out of range");
      assert (MAW >= 2 && MAW <= 30) else $fatal(1, "MAW out of range");
      assert (OP_IMEM != OP_DMEM) else $fatal(1, "opcodes must differ");
   end

   fwl_state_e       st, adv_st;
   fwl_err_e         err_q;
   logic             done_q, swap_q, wr_pass, adv_wr;
   logic             instr_q, tok_q;
   logic [7:0]       idtop_q;
   logic [LEN_W-1:0] size_q, nblk_q, idx_q, adv_idx, off_q, cnt_q, beat_q;
   logic [31:0]      dst_q;
   logic [LEN_W-1:0] addr_c;
   logic [LEN_W:0]   scan_next2;
   logic             last_blk, rd_req, fvalid, emit;
   logic [31:0]      fword, bnd_off;
   logic [LIM_W-1:0] bnd_lim;
   logic             off_bad, limit_bad, overrun_bad;

   // ---------------- read path ----------------
   assign rd_req    = (st != ST_IDLE) && (st != ST_FIN) && !fvalid;
   assign img_rd_en = rd_req;
   assign img_addr  = addr_c;

   always_comb begin
      case (st)
         ST_IDW:            addr_c = LEN_W'(1);
         ST_SIZE:           addr_c = LEN_W'(2);
         ST_SCAN, ST_BTYPE: addr_c = LEN_W'(3) + (idx_q << 1);
         ST_BOFF:           addr_c = LEN_W'(4) + (idx_q << 1);
         ST_BDST:           addr_c = LEN_W'(3) + off_q;
         ST_BCNT:           addr_c = LEN_W'(4) + off_q;
         ST_BDATA:          addr_c = LEN_W'(5) + off_q + beat_q;
         default:           addr_c = '0;
      endcase
   end

   fwl_fetch #(.SWAP_EN(SWAP_EN)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (rd_req),
      .swap_i    (swap_q),
      .img_rdata (img_rdata),
      .fvalid    (fvalid),
      .fword     (fword)
   );

   // ---------------- range checks ----------------
   assign bnd_off = (st == ST_BOFF) ? fword : 32'(off_q);
   assign bnd_lim = instr_q ? imem_limit : dmem_limit;

   fwl_bounds #(.LEN_W(LEN_W), .LIM_W(LIM_W)) u_bounds (
      .off_i       (bnd_off),
      .size_i      (size_q),
      .nblk_i      (nblk_q),
      .dst_i       (dst_q),
      .cnt_i       (fword),
      .lim_i       (bnd_lim),
      .off_bad     (off_bad),
      .limit_bad   (limit_bad),
      .overrun_bad (overrun_bad)
   );

   // ---------------- sequencing helpers ----------------
   assign scan_next2 = ({1'b0, idx_q} + (LEN_W+1)'(1)) << 1;
   assign last_blk   = ({1'b0, idx_q} + (LEN_W+1)'(1)) == {1'b0, nblk_q};

   always_comb begin
      adv_st  = ST_BTYPE;
      adv_idx = idx_q + LEN_W'(1);
      adv_wr  = wr_pass;
      if (last_blk) begin
         adv_idx = '0;
         if (wr_pass) adv_st = ST_FIN;
         else         adv_wr = 1'b1;
      end
   end

   assign emit = (st == ST_BDATA) && fvalid;

   // ---------------- control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         err_q   <= ERR_NONE;
         done_q  <= 1'b0;
         swap_q  <= 1'b0;
         wr_pass <= 1'b0;
         instr_q <= 1'b0;
         tok_q   <= 1'b0;
         idtop_q <= '0;
         size_q  <= '0;
         nblk_q  <= '0;
         idx_q   <= '0;
         off_q   <= '0;
         cnt_q   <= '0;
         beat_q  <= '0;
         dst_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  err_q   <= ERR_NONE;
                  swap_q  <= 1'b0;
                  wr_pass <= 1'b0;
                  idx_q   <= '0;
                  if (engine_busy) begin
                     err_q  <= ERR_BUSY;
                     done_q <= 1'b1;
                  end else begin
                     st <= ST_MAGIC;
                  end
               end
            end
            ST_MAGIC: if (fvalid) begin
               if (fword == MAGIC) begin
                  st <= ST_IDW;
               end else if (SWAP_EN && fword == bswap32(MAGIC)) begin
                  swap_q <= 1'b1;
                  st     <= ST_IDW;
               end else begin
                  err_q <= ERR_MAGIC;
                  st    <= ST_FIN;
               end
            end
            ST_IDW: if (fvalid) begin
               idtop_q <= fword[31:24];
               st      <= ST_SIZE;
            end
            ST_SIZE: if (fvalid) begin
               if ((34'(fword) + 34'd3) != 34'(img_len)) begin
                  err_q <= ERR_SIZE;
                  st    <= ST_FIN;
               end else if (idtop_q[3:0] != engine_id) begin
                  err_q <= ERR_ENGINE;
                  st    <= ST_FIN;
               end else if (legacy_mode && idtop_q[7:4] != 4'd0) begin
                  err_q <= ERR_DEVICE;
                  st    <= ST_FIN;
               end else if (fword == 32'd0) begin
                  err_q <= ERR_NO_EOF;
                  st    <= ST_FIN;
               end else begin
                  size_q <= fword[LEN_W-1:0];
                  idx_q  <= '0;
                  st     <= ST_SCAN;
               end
            end
            ST_SCAN: if (fvalid) begin
               if (fword == TYPE_END) begin
                  nblk_q <= idx_q;
                  idx_q  <= '0;
                  st     <= (idx_q == '0) ? ST_FIN : ST_BTYPE;
               end else if (scan_next2 >= {1'b0, size_q}) begin
                  err_q <= ERR_NO_EOF;
                  st    <= ST_FIN;
               end else begin
                  idx_q <= idx_q + LEN_W'(1);
               end
            end
            ST_BTYPE: if (fvalid) begin
               instr_q <= (fword == TYPE_INSTR);
               tok_q   <= (fword == TYPE_INSTR) || (fword == TYPE_DATA);
               st      <= ST_BOFF;
            end
            ST_BOFF: if (fvalid) begin
               if (off_bad) begin
                  err_q <= ERR_OFFSET;
                  st    <= ST_FIN;
               end else if (!tok_q) begin
                  err_q <= ERR_TYPE;
                  st    <= ST_FIN;
               end else begin
                  off_q <= fword[LEN_W-1:0];
                  st    <= ST_BDST;
               end
            end
            ST_BDST: if (fvalid) begin
               dst_q <= fword;
               st    <= ST_BCNT;
            end
            ST_BCNT: if (fvalid) begin
               if (limit_bad) begin
                  err_q <= ERR_LIMIT;
                  st    <= ST_FIN;
               end else if (overrun_bad) begin
                  err_q <= ERR_OVERRUN;
                  st    <= ST_FIN;
               end else begin
                  cnt_q  <= fword[LEN_W-1:0];
                  beat_q <= '0;
                  if (wr_pass && fword != 32'd0) begin
                     st <= ST_BDATA;
                  end else begin
                     st      <= adv_st;
                     idx_q   <= adv_idx;
                     wr_pass <= adv_wr;
                  end
               end
            end
            ST_BDATA: if (fvalid) begin
               beat_q <= beat_q + LEN_W'(1);
               if ((beat_q + LEN_W'(1)) == cnt_q) begin
                  st      <= adv_st;
                  idx_q   <= adv_idx;
                  wr_pass <= adv_wr;
               end
            end
            ST_FIN: begin
               done_q <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   fwl_cmd_out #(.MAW(MAW), .OP_IMEM(OP_IMEM), .OP_DMEM(OP_DMEM)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .emit      (emit),
      .is_instr  (instr_q),
      .addr_i    (dst_q[MAW-1:0] + MAW'(beat_q)),
      .data_i    (fword),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data)
   );

   assign busy     = (st != ST_IDLE);
   assign done     = done_q;
   assign err_code = err_q;

   // ---------------- assertions ----------------
   AST_CMD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (err_code == 4'd0)); // R13

   AST_CMD_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> ({1'b0, cmd_addr} < ((cmd_op == OP_IMEM) ? imem_limit : dmem_limit))); // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R14

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R14

   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(err_code)); // R14

endmodule

// File: tb/fw_image_loader_test.sv
module fw_image_loader_test;

   localparam int          CLK_PERIOD = 10;
   localparam int          LW         = 8;
   localparam int          MW         = 6;
   localparam logic [31:0] MAGIC      = 32'hFEEDF00D;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [LW-1:0] img_len = '0;
   logic [3:0]    engine_id = 4'd2;
   logic          legacy_mode = 1'b0;
   logic          engine_busy = 1'b0;
   logic [MW:0]   imem_limit = 7'd40;
   logic [MW:0]   dmem_limit = 7'd48;
   logic          img_rd_en;
   logic [LW-1:0] img_addr;
   logic [31:0]   img_rdata = '0;
   logic          busy, done, cmd_valid;
   logic [3:0]    err_code;
   logic [7:0]    cmd_op;
   logic [MW-1:0] cmd_addr;
   logic [31:0]   cmd_data;

   fw_image_loader #(.LEN_W(LW), .MAW(MW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
      .engine_id(engine_id), .legacy_mode(legacy_mode), .engine_busy(engine_busy),
      .imem_limit(imem_limit), .dmem_limit(dmem_limit),
      .img_rd_en(img_rd_en), .img_addr(img_addr), .img_rdata(img_rdata),
      .busy(busy), .done(done), .err_code(err_code),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [31:0] ram [0:255];
   always @(posedge clk) if (img_rd_en) img_rdata <= ram[img_addr];

   int n_cmp = 0, n_bad = 0, len = 0;
   int bt [0:3], bd [0:3], bc [0:3], bo [0:3];
   int e_n = 0, log_n = 0;
   int e_op [0:255], e_addr [0:255];
   logic [31:0] e_data [0:255];
   logic [7:0]    l_op [0:255];
   logic [MW-1:0] l_addr [0:255];
   logic [31:0]   l_data [0:255];
   bit finished = 0;

   always @(negedge clk) begin
      if (cmd_valid) begin
         if (log_n < 256) begin
            l_op[log_n] = cmd_op; l_addr[log_n] = cmd_addr; l_data[log_n] = cmd_data;
         end
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   function automatic logic [31:0] pat(input int b, input int j);
      return 32'hA5000000 ^ (32'(b) << 20) ^ (32'(j) * 32'h00010101);
   endfunction

   function automatic logic [31:0] bsw(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   // Lay out header, table, end marker and code blocks back to back.
   task automatic build(input int nbk, input int eng, input int dev);
      int p;
      p = 2*nbk + 1;
      for (int i = 0; i < 256; i++) ram[i] = '0;
      e_n = 0;
      for (int b = 0; b < nbk; b++) begin
         ram[3+2*b] = 32'(bt[b]);
         ram[4+2*b] = 32'(p);
         bo[b] = p;
         ram[3+p] = 32'(bd[b]);
         ram[4+p] = 32'(bc[b]);
         for (int j = 0; j < bc[b]; j++) begin
            ram[5+p+j] = pat(b, j);
            e_op[e_n] = (bt[b] == 0) ? 32'h11 : 32'h13;
            e_addr[e_n] = bd[b] + j;
            e_data[e_n] = pat(b, j);
            e_n++;
         end
         p = p + 2 + bc[b];
      end
      ram[3+2*nbk] = 32'hF;
      ram[0] = MAGIC;
      ram[1] = (32'(dev) << 28) | (32'(eng) << 24) | 32'h00030201;
      ram[2] = 32'(p);
      len = p + 3;
   endtask

   task automatic swap_img();
      for (int i = 0; i < len; i++) ram[i] = bsw(ram[i]);
   endtask

   task automatic run(input int exp_err, input string req);
      int cyc;
      int en;
      img_len = LW'(len);
      log_n = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy == (exp_err != 1), {req, " busy after start"}, busy, exp_err != 1);
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         chk(0, {req, " run timeout"}, cyc, 5000);
      end else begin
         chk(!busy, {req, " busy at done"}, busy, 0);
         chk(err_code == exp_err, {req, " error code"}, err_code, exp_err);
         en = (exp_err == 0) ? e_n : 0;
         chk(log_n == en, {req, " command count"}, log_n, en);
         if (log_n == en) begin
            for (int k = 0; k < en; k++) begin
               chk(l_op[k] == e_op[k], {req, " opcode"}, l_op[k], e_op[k]);
               chk(l_addr[k] == MW'(e_addr[k]), {req, " address"}, l_addr[k], e_addr[k]);
               chk(l_data[k] == e_data[k], {req, " data"}, l_data[k], e_data[k]);
            end
         end
         @(negedge clk);
         chk(!done, "R14 done lasts one cycle", done, 0);
         @(negedge clk);
         chk(err_code == exp_err, "R14 error code held", err_code, exp_err);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      chk(0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(!busy && !done && !cmd_valid && err_code == 0, "R1 during reset",
          {busy, done, cmd_valid, err_code}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !done && !cmd_valid && err_code == 0, "R1 after reset",
          {busy, done, cmd_valid, err_code}, 0);

      // R12 basic load: instruction block then data block
      bt[0] = 0; bd[0] = 3;  bc[0] = 4;
      bt[1] = 1; bd[1] = 10; bc[1] = 3;
      build(2, 2, 0);
      run(0, "R12 two blocks");

      // R3 byte-swapped image gives the same commands
      swap_img();
      run(0, "R3 swapped image");

      // R3 bad magic
      build(2, 2, 0);
      ram[0] = 32'hFEEDF00E;
      run(2, "R3 bad magic");

      // R4 size mismatch in both directions
      build(2, 2, 0);
      len = len + 1;
      run(3, "R4 length too long");
      build(2, 2, 0);
      len = len - 1;
      run(3, "R4 length too short");

      // R5 engine mismatch
      engine_id = 4'd3;
      build(2, 2, 0);
      run(4, "R5 engine mismatch");
      engine_id = 4'd2;

      // R6 device field with and without legacy mode
      legacy_mode = 1'b1;
      build(2, 2, 1);
      run(5, "R6 device rejected");
      build(2, 2, 0);
      run(0, "R6 device zero accepted");
      legacy_mode = 1'b0;
      build(2, 2, 1);
      run(0, "R6 device ignored");

      // R7 no end marker within the payload
      for (int i = 0; i < 256; i++) ram[i] = '0;
      ram[0] = MAGIC; ram[1] = 32'h02000000; ram[2] = 32'd4;
      ram[3] = 0; ram[4] = 1; ram[5] = 0; ram[6] = 1;
      len = 7;
      run(6, "R7 missing end marker");
      ram[2] = 32'd0; len = 3;
      run(6, "R7 empty payload");

      // R8 offset checks
      bt[0] = 0; bd[0] = 0; bc[0] = 2;
      build(1, 2, 0);
      ram[4] = 32'd2;
      run(7, "R8 offset inside table");
      build(1, 2, 0);
      ram[4] = 32'(len - 3 - 1);
      run(7, "R8 offset past size-2");
      bt[0] = 0; bd[0] = 5; bc[0] = 2;
      bt[1] = 1; bd[1] = 7; bc[1] = 0;
      build(2, 2, 0);
      run(0, "R8 offset at size-2 accepted");

      // R9/R13 bad type in second entry blocks the valid first one
      bt[0] = 0; bd[0] = 1; bc[0] = 3;
      bt[1] = 2; bd[1] = 1; bc[1] = 1;
      build(2, 2, 0);
      run(8, "R9 R13 bad type");

      // R10 limit boundaries for both memories
      bt[0] = 0; bd[0] = 36; bc[0] = 4;
      bt[1] = 1; bd[1] = 45; bc[1] = 3;
      build(2, 2, 0);
      run(0, "R10 exact limits accepted");
      bd[0] = 37;
      build(2, 2, 0);
      run(9, "R10 instruction limit");
      bd[0] = 36; bd[1] = 46;
      build(2, 2, 0);
      run(9, "R10 R13 data limit after valid block");

      // R11 block runs past payload end
      bt[0] = 1; bd[0] = 0; bc[0] = 3;
      build(1, 2, 0);
      ram[3+bo[0]+1] = 32'd4;
      run(10, "R11 overrun");

      // R2 engine busy
      engine_busy = 1'b1;
      build(1, 2, 0);
      run(1, "R2 engine busy");
      engine_busy = 1'b0;

      // R12 sweep over table sizes and counts, alternating byte order
      for (int nbk = 0; nbk < 4; nbk++) begin
         for (int c = 0; c < 5; c++) begin
            for (int b = 0; b < nbk; b++) begin
               bt[b] = (b + c) % 2;
               bd[b] = (b*7 + c*3) % 30;
               bc[b] = (b + c) % 5;
            end
            build(nbk, 2, 0);
            if (((nbk + c) % 2) == 1) swap_img();
            run(0, "R12 R3 sweep");
         end
      end

      summary();
   end

endmodule